// File: doc/BRIEF.md
# Watchdog Timer with Selectable Dual-Command Restart

This block is a free-running watchdog. A prescaler divides the block clock. A tap counter then counts prescaler ticks until it reaches one of four selectable limits. On reaching the limit, the block either asks for a system reset or, when the device has been halted, asks for a wake-up. Software keeps the watchdog from expiring by sending restart commands. It also sends a halt command when the device enters its low-power state. Two status flags are kept: `to_flag` records an expiry and `pd_flag` records a power-down.

A static option chooses how the watchdog is restarted.

- **Single-command mode:** one command restarts it.
- **Two-command mode:** two distinct commands (`clr_a` and `clr_b`) must arrive one after the other, in either order. Sending the same half again has no effect. A half that is already recorded is dropped when the watchdog expires or a halt is taken.

The reset generator and the clock source sit outside the block. All control inputs are single-cycle pulses, and every output is registered. The block has no streaming data path, so no port uses a valid/ready handshake.

Top module: `wdt_core`

## Requirements
- R1: While `rst_n` is low, `rst_req`, `wake_req`, `to_flag`, `pd_flag` and `halted` are all 0.
- R2: With `tap_sel` = s held and no commands sent, the watchdog expires exactly 2^(PRE_W+TAP_BASE+s) clock edges after the edge that last restarted it (16, 32, 64 or 128 cycles with the defaults). The count then restarts from zero.
- R3: An expiry while not halted raises `rst_req` for exactly one cycle and sets `to_flag`; `pd_flag` keeps its value.
- R4: With `cfg_dual` = 0, a `clr_one` pulse restarts the count and clears `to_flag` and `pd_flag`; `clr_a` and `clr_b` are ignored.
- R5: With `cfg_dual` = 1, `clr_one` is ignored. A `clr_a` pulse followed later by a `clr_b` pulse (or `clr_b` then `clr_a`) restarts the count and clears both flags on the edge of the second pulse. A cycle with `clr_a` and `clr_b` both high counts as no command.
- R6: With `cfg_dual` = 1, repeating the same half (`clr_a` again after `clr_a`, or `clr_b` again after `clr_b`) changes nothing.
- R7: A recorded half is discarded by an expiry or a taken halt, so a later lone opposite half does not restart the watchdog.
- R8: A `halt_cmd` pulse while not halted restarts the count, sets `pd_flag` and `halted`, and clears `to_flag`. It takes priority over a restart command in the same cycle.
- R9: An expiry while halted raises `wake_req` for one cycle instead of `rst_req`, clears `halted`, sets `to_flag` and leaves `pd_flag` at 1.
- R10: While `halted` is 1, `clr_one`, `clr_a`, `clr_b` and `halt_cmd` have no effect.
- R11: A restart or halt command accepted in the same cycle as an expiry wins: no `rst_req` or `wake_req` follows, and the count restarts.
- R12: `rst_req` and `wake_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | Static option: 0 selects single-command restart, 1 selects two-command restart |
| tap_sel | input | SEL_W | Selects the expiry limit from four counter taps |
| clr_one | input | 1 | Single restart command pulse |
| clr_a | input | 1 | First half of the two-command restart |
| clr_b | input | 1 | Second half of the two-command restart |
| halt_cmd | input | 1 | Power-down entry command pulse |
| rst_req | output | 1 | One-cycle reset request on expiry while running |
| wake_req | output | 1 | One-cycle wake request on expiry while halted |
| to_flag | output | 1 | Expiry status flag |
| pd_flag | output | 1 | Power-down status flag |
| halted | output | 1 | Device is in the halted state |

## Verification
The assertions assume that `cfg_dual` changes only while `rst_n` is low, because the restart-mode properties read it as a static strap. The bench sets it only inside a reset window. The assertions also assume that command pulses are sampled at clock edges, with no constraint on how they overlap. The random stimulus therefore lets `clr_a` and `clr_b` coincide, lets halts fall next to restarts, and changes `tap_sel` mid-count, so the priority and tap-compare paths are exercised inside those assumptions.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    HALF_NONE = 2'd0,
    HALF_A    = 2'd1,
    HALF_B    = 2'd2
  } half_e;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int PRE_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == PRE_LAST);
endmodule

// File: rtl/wdt_tap_count.sv
module wdt_tap_count #(
  parameter int TAP_BASE = 2,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             expire
);
  localparam int NUM_TAPS = 1 << SEL_W;
  localparam int CNT_W    = TAP_BASE + NUM_TAPS - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit_tab [NUM_TAPS];

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign limit_tab[g] = CNT_W'((64'd1 << (TAP_BASE + g)) - 64'd1);
  end

  // Magnitude compare so a lowered tap still expires at the next tick.
  assign expire = tick && (cnt_q >= limit_tab[tap_sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart || expire) cnt_q <= '0;
    else if (tick)              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_clear_seq.sv
module wdt_clear_seq
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_dual,
  input  logic accept,
  input  logic flush,
  input  logic clr_one,
  input  logic clr_a,
  input  logic clr_b,
  output logic clear_ok
);
  half_e seen_q, seen_d;
  logic  a_only, b_only;

  assign a_only = clr_a && !clr_b;
  assign b_only = clr_b && !clr_a;

  always_comb begin
    if (!cfg_dual) clear_ok = accept && clr_one;
    else           clear_ok = accept && ((a_only && seen_q == HALF_B) ||
                                         (b_only && seen_q == HALF_A));
  end

  always_comb begin
    seen_d = seen_q;
    if (!cfg_dual || flush || clear_ok) seen_d = HALF_NONE;
    else if (accept && a_only)          seen_d = HALF_A;
    else if (accept && b_only)          seen_d = HALF_B;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= HALF_NONE;
    else        seen_q <= seen_d;
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int PRE_W    = 2,
  parameter int TAP_BASE = 2,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dual,
  input  logic [SEL_W-1:0] tap_sel,
  input  logic             clr_one,
  input  logic             clr_a,
  input  logic             clr_b,
  input  logic             halt_cmd,
  output logic             rst_req,
  output logic             wake_req,
  output logic             to_flag,
  output logic             pd_flag,
  output logic             halted
);
  logic tick, expire, clear_ok, take_halt, restart, timeout;

  assign take_halt = halt_cmd && !halted;
  assign restart   = take_halt || clear_ok;
  assign timeout   = expire && !restart;

  wdt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  wdt_tap_count #(.TAP_BASE(TAP_BASE), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .tap_sel(tap_sel), .expire(expire)
  );

  wdt_clear_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .accept(!halted),
    .flush(take_halt || timeout), .clr_one(clr_one), .clr_a(clr_a),
    .clr_b(clr_b), .clear_ok(clear_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      to_flag  <= 1'b0;
      pd_flag  <= 1'b0;
      halted   <= 1'b0;
    end else begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      if (take_halt) begin
        halted  <= 1'b1;
        pd_flag <= 1'b1;
        to_flag <= 1'b0;
      end else if (clear_ok) begin
        to_flag <= 1'b0;
        pd_flag <= 1'b0;
      end else if (timeout) begin
        to_flag <= 1'b1;
        if (halted) begin
          halted   <= 1'b0;
          wake_req <= 1'b1;
        end else begin
          rst_req  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_dual,
  input logic [SEL_W-1:0] tap_sel,
  input logic             clr_one,
  input logic             clr_a,
  input logic             clr_b,
  input logic             halt_cmd,
  input logic             rst_req,
  input logic             wake_req,
  input logic             to_flag,
  input logic             pd_flag,
  input logic             halted
);
  logic unused_ok;
  assign unused_ok = ^{tap_sel, clr_a, clr_b};

  a_r12_no_dual_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && wake_req));

  a_r3_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r3_rst_sets_to: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (to_flag && !halted));

  a_r9_wake_state: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (to_flag && pd_flag && !halted));

  a_r9_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

  a_r8_halt_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_cmd && !halted) |=> (halted && pd_flag && !to_flag && !rst_req && !wake_req));

  a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted || wake_req));

  a_r4_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dual && clr_one && !halt_cmd && !halted) |=> (!to_flag && !pd_flag && !rst_req));

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!rst_req && !wake_req && !to_flag && !pd_flag && !halted));
endmodule

bind wdt_core wdt_core_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/wdt_core_test.sv
`timescale 1ns/1ps
module wdt_core_test;
  localparam int PRE_W    = 2;
  localparam int TAP_BASE = 2;
  localparam int SEL_W    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dual = 1'b0;
  logic [SEL_W-1:0] tap_sel = '0;
  logic clr_one = 1'b0, clr_a = 1'b0, clr_b = 1'b0, halt_cmd = 1'b0;
  logic rst_req, wake_req, to_flag, pd_flag, halted;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_el, m_trk;
  bit m_to, m_pd, m_halt, m_rst, m_wake;

  always #4 clk = ~clk;

  wdt_core #(.PRE_W(PRE_W), .TAP_BASE(TAP_BASE), .SEL_W(SEL_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .tap_sel(tap_sel),
    .clr_one(clr_one), .clr_a(clr_a), .clr_b(clr_b), .halt_cmd(halt_cmd),
    .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag),
    .pd_flag(pd_flag), .halted(halted)
  );

  function automatic int limit_of(input int s);
    return (1 << (TAP_BASE + s)) - 1;
  endfunction

  task automatic model_reset();
    m_el = 0; m_trk = 0; m_to = 0; m_pd = 0; m_halt = 0; m_rst = 0; m_wake = 0;
  endtask

  task automatic model_step(input bit one, input bit a, input bit b, input bit h);
    int per;
    bit tick, tout, ok;
    per  = 1 << PRE_W;
    tick = (m_el % per) == per - 1;
    tout = tick && ((m_el / per) >= limit_of(int'(tap_sel)));
    ok = 0;
    m_rst = 0; m_wake = 0;
    if (!m_halt) begin
      if (h) begin
        m_el = 0; m_pd = 1; m_to = 0; m_halt = 1; m_trk = 0;
        return;
      end
      if (!cfg_dual) ok = one;
      else if (a && !b) begin
        if (m_trk == 2) ok = 1; else m_trk = 1;
      end else if (b && !a) begin
        if (m_trk == 1) ok = 1; else m_trk = 2;
      end
      if (ok) begin
        m_el = 0; m_to = 0; m_pd = 0; m_trk = 0;
        return;
      end
    end
    if (tout) begin
      m_el = 0; m_to = 1; m_trk = 0;
      if (m_halt) begin m_halt = 0; m_wake = 1; end
      else m_rst = 1;
    end else begin
      m_el++;
    end
  endtask

  task automatic chk1(input string tag, input string name, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, name, got, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk1(tag, "rst_req", rst_req, m_rst);
    chk1(tag, "wake_req", wake_req, m_wake);
    chk1(tag, "to_flag", to_flag, m_to);
    chk1(tag, "pd_flag", pd_flag, m_pd);
    chk1(tag, "halted", halted, m_halt);
    chk1("R12", "pulse overlap", rst_req && wake_req, 1'b0);
  endtask

  // Called at a falling edge: drive, advance the model over the next rising edge, compare.
  task automatic cyc(input bit one, input bit a, input bit b, input bit h, input string tag);
    clr_one = one; clr_a = a; clr_b = b; halt_cmd = h;
    model_step(one, a, b, h);
    @(negedge clk);
    clr_one = 0; clr_a = 0; clr_b = 0; halt_cmd = 0;
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, tag);
  endtask

  task automatic do_reset(input bit dual);
    @(negedge clk);
    rst_n = 0; cfg_dual = dual; tap_sel = '0;
    clr_one = 0; clr_a = 0; clr_b = 0; halt_cmd = 0;
    model_reset();
    @(negedge clk);
    compare("R1");
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic random_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int r;
      r = int'($urandom % 1000);
      if ($urandom % 300 == 0) tap_sel = SEL_W'($urandom);
      cyc(r < 15, (r >= 15 && r < 30) || (r >= 45 && r < 48),
          (r >= 30 && r < 45) || (r >= 45 && r < 48), r >= 48 && r < 53, tag);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    // single-command mode
    do_reset(1'b0);
    idle(20, "R2");                 // expiry after 16 edges, R3 pulse
    cyc(1, 0, 0, 0, "R4");          // clear flags
    idle(5, "R4");
    cyc(0, 1, 0, 0, "R4");          // ignored halves
    cyc(0, 0, 1, 0, "R4");
    idle(15, "R3");
    tap_sel = 2'd2;
    cyc(1, 0, 0, 0, "R4");
    idle(70, "R2");                 // 64-edge period
    tap_sel = 2'd0;
    cyc(0, 0, 0, 1, "R8");
    idle(4, "R8");
    cyc(1, 0, 0, 0, "R10");
    cyc(0, 0, 0, 1, "R10");
    idle(20, "R9");                 // wake instead of reset
    cyc(1, 0, 0, 0, "R4");
    idle(15, "R11");
    cyc(1, 0, 0, 0, "R11");         // clear on the expiry cycle
    idle(3, "R11");
    // two-command mode
    do_reset(1'b1);
    idle(17, "R3");
    cyc(1, 0, 0, 0, "R5");          // single command ignored
    cyc(0, 1, 0, 0, "R5");
    idle(2, "R5");
    cyc(0, 0, 1, 0, "R5");          // completes restart
    idle(3, "R5");
    cyc(0, 0, 1, 0, "R5");
    cyc(0, 1, 0, 0, "R5");          // reverse order
    cyc(0, 1, 1, 0, "R5");          // both at once: no command
    idle(10, "R6");
    cyc(0, 1, 0, 0, "R6");
    cyc(0, 1, 0, 0, "R6");
    cyc(0, 1, 0, 0, "R6");          // repeated half
    idle(6, "R6");
    cyc(0, 1, 0, 0, "R7");
    idle(20, "R7");                 // expiry drops recorded half
    cyc(0, 0, 1, 0, "R7");          // lone half: flag stays set
    idle(2, "R7");
    cyc(0, 1, 0, 0, "R7");
    cyc(0, 0, 0, 1, "R8");          // halt drops recorded half
    idle(20, "R9");
    cyc(0, 0, 1, 0, "R7");
    idle(2, "R7");
    // random phases
    do_reset(1'b0);
    random_run(4000, "R2");
    do_reset(1'b1);
    random_run(4000, "R5");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule